// File: doc/BRIEF.md
# Segment Offset Correction Table

This block sits on the output of a pipelined analog-to-digital converter whose inter-stage gains are deliberately a little below two. That choice leaves gaps in the raw transfer curve at the major transitions. The top bits of every raw code name the segment of the curve the sample falls in. A small register table holds one signed offset per segment. Adding that offset to the raw code closes the gaps and gives a continuous transfer curve.

The table comes out of reset holding nominal offsets derived from the designed gap sizes. A separate update engine can replace any entry at any time through a plain write port. A write never stalls conversion samples: a sample corrected in the same cycle as a write still sees the old entry. The lookup and the addition are registered. When the consumer is ready, the result appears one cycle after the sample is accepted. A corrected value that would leave the raw code range is clamped to the nearest end.

The sample stream uses valid/ready on both sides. A sample is taken when `smp_valid` and `smp_ready` are both high at a clock edge. A result leaves when `cor_valid` and `cor_ready` are both high. While a result is held and the consumer is not ready, `smp_ready` is low and the held result does not change. Writes to the table never depend on, or affect, the stream handshake.

Top module: `seg_offset_corrector`

## Requirements
- R1: After reset `cor_valid` is 0 and the table holds, for segments 0 to 7 in order, the signed offsets +6, +5, +3, +2, -2, -3, -5, -6.
- R2: The segment index is raw code bits [9:7]. The corrected code is the raw code plus the selected 4-bit two's complement entry, sign-extended.
- R3: A sum above 1023 is output as 1023.
- R4: A sum below 0 is output as 0.
- R5: A sample accepted at edge k is presented with `cor_valid` high after edge k. With no new sample accepted and no stall, `cor_valid` is low after the next edge.
- R6: When `tbl_wr` is high at an edge, entry `tbl_idx` takes `tbl_val` (4-bit two's complement). A sample accepted at that same edge is corrected with the old entry, and later samples use the new one.
- R7: `smp_ready` is low exactly when `cor_valid` is high and `cor_ready` is low. While that holds, `cor_valid` stays high and `cor_code` stays unchanged.
- R8: A table write never lowers `smp_ready` and never changes a result already held at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Raw sample present |
| smp_ready | output | 1 | Block can take a sample this cycle |
| smp_code | input | 10 | Raw converter code |
| cor_valid | output | 1 | Corrected result present |
| cor_ready | input | 1 | Consumer takes the result |
| cor_code | output | 10 | Corrected, clamped code |
| tbl_wr | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Entry to write |
| tbl_val | input | 4 | New signed entry value |

## Verification
The assertions check the handshake rules on every cycle: back-pressure lowers `smp_ready`, a stalled result holds its value, an accepted sample yields a valid result one edge later, an idle cycle empties the output, and a write never blocks intake. The arithmetic can only be shown by the bench's scenarios. These cover the nominal offsets in every segment, continuity across a segment border, clamping at both range ends after entries are rewritten, the old-value rule for a write in the same cycle as a sample, and a write made while a result is held.

// File: rtl/seg_corr_pkg.sv
`timescale 1ns/1ps
package seg_corr_pkg;

  // Number of trailing zero bits of a positive value.
  function automatic int trailing_zeros(input int v);
    int n;
    n = 0;
    for (int b = 0; b < 31; b++) begin
      if (((v >> b) & 1) == 0 && n == b) n = b + 1;
    end
    return n;
  endfunction

  // Nominal offset for a segment. The gap at the border just below segment t
  // is 2**tz(t) codes. The offset centres the total gap, then takes away the
  // gaps already crossed.
  function automatic int nominal_offset(input int seg, input int seg_bits);
    int cum;
    int total;
    cum = 0;
    for (int t = 1; t < (1 << seg_bits); t++) begin
      if (t <= seg) cum = cum + (1 << trailing_zeros(t));
    end
    total = seg_bits * (1 << (seg_bits - 1));
    return (total / 2) - cum;
  endfunction

endpackage

// File: rtl/seg_corr_table.sv
`timescale 1ns/1ps
module seg_corr_table #(
  parameter int SEG_W = 3,
  parameter int ENT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_val,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_val
);
  localparam int NSEG = 1 << SEG_W;

  logic [ENT_W-1:0] entry [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    localparam logic [ENT_W-1:0] NOM =
      ENT_W'(seg_corr_pkg::nominal_offset(g, SEG_W));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[g] <= NOM;
      else if (wr_en && (wr_idx == SEG_W'(g)))
        entry[g] <= wr_val;
    end
  end

  // The read comes from the registers, so a sample in the same cycle as a
  // write sees the value from before the edge.
  assign rd_val = entry[rd_idx];

endmodule

// File: rtl/seg_corr_add.sv
`timescale 1ns/1ps
module seg_corr_add #(
  parameter int CODE_W = 10,
  parameter int ENT_W  = 4
) (
  input  logic [CODE_W-1:0] raw,
  input  logic [ENT_W-1:0]  ofs,
  output logic [CODE_W-1:0] fixed
);
  localparam int SUM_W = CODE_W + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << CODE_W) - 1);

  logic signed [SUM_W-1:0] raw_s;
  logic signed [SUM_W-1:0] ofs_s;
  logic signed [SUM_W-1:0] sum;

  assign raw_s = $signed({2'b00, raw});
  assign ofs_s = $signed({{(SUM_W-ENT_W){ofs[ENT_W-1]}}, ofs});
  assign sum   = raw_s + ofs_s;

  always_comb begin
    if (sum < 0)
      fixed = '0;
    else if (sum > MAXV)
      fixed = MAXV[CODE_W-1:0];
    else
      fixed = sum[CODE_W-1:0];
  end

endmodule

// File: rtl/seg_corr_stage.sv
`timescale 1ns/1ps
module seg_corr_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) out_data <= in_data;
    end
  end

endmodule

// File: rtl/seg_offset_corrector.sv
`timescale 1ns/1ps
module seg_offset_corrector #(
  parameter int CODE_W = 10,
  parameter int SEG_W  = 3,
  parameter int ENT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CODE_W-1:0] smp_code,
  output logic              cor_valid,
  input  logic              cor_ready,
  output logic [CODE_W-1:0] cor_code,
  input  logic              tbl_wr,
  input  logic [SEG_W-1:0]  tbl_idx,
  input  logic [ENT_W-1:0]  tbl_val
);
  logic [SEG_W-1:0]  seg;
  logic [ENT_W-1:0]  ofs;
  logic [CODE_W-1:0] fixed;

  assign seg = smp_code[CODE_W-1 -: SEG_W];

  seg_corr_table #(.SEG_W(SEG_W), .ENT_W(ENT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_val(tbl_val),
    .rd_idx(seg), .rd_val(ofs)
  );

  seg_corr_add #(.CODE_W(CODE_W), .ENT_W(ENT_W)) u_add (
    .raw(smp_code), .ofs(ofs), .fixed(fixed)
  );

  seg_corr_stage #(.W(CODE_W)) u_stg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(smp_valid), .in_ready(smp_ready), .in_data(fixed),
    .out_valid(cor_valid), .out_ready(cor_ready), .out_data(cor_code)
  );

endmodule

// File: rtl/seg_corr_chk.sv
`timescale 1ns/1ps
module seg_corr_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              cor_valid,
  input logic              cor_ready,
  input logic [CODE_W-1:0] cor_code,
  input logic              tbl_wr
);
  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_valid && !cor_ready) |-> !smp_ready);

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_valid && !cor_ready) |=> (cor_valid && $stable(cor_code)));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> cor_valid);

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(smp_valid && smp_ready) && !(cor_valid && !cor_ready)) |=> !cor_valid);

  p_write_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr && !cor_valid) |-> smp_ready);

endmodule

bind seg_offset_corrector seg_corr_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .cor_valid(cor_valid), .cor_ready(cor_ready), .cor_code(cor_code),
  .tbl_wr(tbl_wr)
);

// File: tb/sim_seg_offset_corrector.sv
`timescale 1ns/1ps
module sim_seg_offset_corrector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_code = '0;
  logic       cor_valid;
  logic       cor_ready = 1'b1;
  logic [9:0] cor_code;
  logic       tbl_wr = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [3:0] tbl_val = '0;

  int checks = 0;
  int errors = 0;
  int model [8] = '{6, 5, 3, 2, -2, -3, -5, -6};  // R1 nominal offsets
  int    exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  seg_offset_corrector u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_code(smp_code), .cor_valid(cor_valid), .cor_ready(cor_ready),
    .cor_code(cor_code), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_val(tbl_val)
  );

  function automatic int expect_of(input int code);
    int v;
    v = code + model[code >> 7];
    if (v > 1023) v = 1023;
    if (v < 0) v = 0;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: offers one sample until taken, optionally writing the table at
  // the acceptance edge; expected value uses the table before that edge.
  task automatic xfer(input int code, input bit wr, input int idx,
                      input int val, input string tag);
    bit acc;
    bit w;
    w = wr;
    do begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_code  = code[9:0];
      tbl_wr    = w;
      tbl_idx   = idx[2:0];
      tbl_val   = val[3:0];
      #1;
      acc = smp_ready;
      if (acc) begin
        exp_q.push_back(expect_of(code));
        tag_q.push_back(tag);
      end
      @(posedge clk);
      if (w) model[idx] = (val > 7) ? val - 16 : val;
      w = 1'b0;
    end while (!acc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      tbl_wr    = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard on every output transfer.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && cor_valid && cor_ready) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected output", 1, 0);
        end else begin
          check(tag_q.pop_front(), int'(cor_code), exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    #1;
    check("R1 cor_valid after reset", int'(cor_valid), 0);
    check("R7 smp_ready after reset", int'(smp_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: nominal offset in each segment, mid-segment codes
    for (int s = 0; s < 8; s++) xfer(s * 128 + 64, 0, 0, 0, "R1 nominal segment");

    // R2: segment border continuity and range ends with nominal table
    xfer(127, 0, 0, 0, "R2 seg0 top");
    xfer(128, 0, 0, 0, "R2 seg1 bottom");
    xfer(0, 0, 0, 0, "R2 code 0");
    xfer(1023, 0, 0, 0, "R2 code 1023");

    // R2: pseudo-random stream, back to back
    lfsr = 10'h2a5;
    for (int i = 0; i < 40; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 9) ^ (lfsr >> 6)) & 1)) & 10'h3ff;
      xfer(lfsr, 0, 0, 0, "R2 stream");
    end

    // R5: exact one-cycle latency, then empty
    idle(2);
    xfer(200, 0, 0, 0, "R5 latency data");
    @(negedge clk);
    smp_valid = 1'b0;
    #1;
    check("R5 valid one edge after accept", int'(cor_valid), 1);
    @(negedge clk);
    #1;
    check("R5 valid low after idle edge", int'(cor_valid), 0);

    // R3: upper clamp after entry 7 set to +7 (4'b0111)
    xfer(1000, 1, 7, 7, "R6 old entry 7");
    xfer(1020, 0, 0, 0, "R3 clamp 1020");
    xfer(1023, 0, 0, 0, "R3 clamp 1023");
    xfer(1016, 0, 0, 0, "R3 exact 1023");

    // R4: lower clamp after entry 0 set to -8 (4'b1000)
    xfer(10, 1, 0, 8, "R6 old entry 0");
    xfer(3, 0, 0, 0, "R4 clamp 3");
    xfer(0, 0, 0, 0, "R4 clamp 0");
    xfer(8, 0, 0, 0, "R4 exact 0");
    xfer(9, 0, 0, 0, "R4 just above 0");

    // R6: write and sample to the same segment at the same edge
    xfer(300, 1, 2, 15, "R6 same edge uses old");
    xfer(300, 0, 0, 0, "R6 next sample uses new");

    // R7 / R8: stall with a held result while the table is rewritten
    idle(2);
    @(negedge clk);
    cor_ready = 1'b0;
    xfer(400, 0, 0, 0, "R7 stalled result");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_code  = 10'd50;
      tbl_wr    = (i == 0);
      tbl_idx   = 3'd3;
      tbl_val   = 4'd7;
      #1;
      check("R7 valid held", int'(cor_valid), 1);
      check("R8 held code unchanged by write", int'(cor_code), 402);
      check("R7 ready low in stall", int'(smp_ready), 0);
      @(posedge clk);
      if (i == 0) model[3] = 7;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    tbl_wr    = 1'b0;
    cor_ready = 1'b1;
    xfer(400, 0, 0, 0, "R8 write during stall applied");
    idle(2);

    while (exp_q.size() != 0) idle(1);
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule